// File: doc/BRIEF.md
# Virtualization Instruction Trap Checker

This block decides, for one decoded privileged instruction per cycle, whether the instruction executes normally, raises an illegal-instruction exception or raises a virtual-instruction exception. It takes four inputs: the current privilege mode, a one-hot class vector that marks the instruction kind, the hypervisor status trap controls, and the machine-level wait and translation trap controls. The decoder feeds it in parallel with the execute stage.

The decision is combinational. It is captured in one output register stage that has a clock enable (`in_valid`). For a return-from-supervisor instruction that is allowed to proceed, the block also reports the privilege mode the hart lands in. The trap unit uses this to switch modes. The wait-for-interrupt timeout itself is handled elsewhere. This block only classifies the instruction.

Top module: `vtrap_checker`

## Requirements
- R1: The result appears one clock after `in_valid` is sampled high, with `out_valid` high in that cycle. `out_code` uses 00 = execute, 01 = illegal-instruction, 10 = virtual-instruction, and 11 never appears. When `in_valid` is low, `out_valid` goes low and the other outputs keep their previous values. Reset clears all outputs to zero.
- R2: Mode codes are `in_priv` 0 = M, 1 = HS, 2 = U, 3 = VS, 4 = VU. In M-mode no class traps. With no class bit set, the outcome is execute in every mode.
- R3: Class bits are 0 wfi, 1 sret, 2 sfence.vma, 3 sinval.vma, 4 satp access, 5 hypervisor load/store, 6 hfence.vvma. With `m_tw` = 1, wfi is illegal in HS, U, VS and VU.
- R4: With `m_tw` = 0, wfi behaves as follows. It executes in HS. It is illegal in U. In VS it executes when `h_vtw` = 0 and is virtual when `h_vtw` = 1. It is virtual in VU.
- R5: In VS-mode, sret is virtual when `h_vtsr` = 1. Otherwise it executes and returns to VS when `vs_spp` = 1 and to VU when `vs_spp` = 0.
- R6: In M or HS, sret executes and returns to one of four modes:

  | `h_spv` | `m_spp` | Return mode |
  |---|---|---|
  | 1 | 1 | VS |
  | 1 | 0 | VU |
  | 0 | 1 | HS |
  | 0 | 0 | U |

  sret in U is illegal and in VU is virtual.
- R7: sfence.vma, sinval.vma and satp access behave as follows:
  - In VS they are virtual when `h_vtvm` = 1 and execute otherwise.
  - In VU they are virtual.
  - In U they are illegal.
- R8: `m_tvm` = 1 makes sfence.vma, sinval.vma and satp access illegal in HS. `m_tvm` has no effect in VS or any other mode.
- R9: hfence.vvma executes in M and HS, is illegal in U and is virtual in VS and VU, whatever `h_vtvm` is.
- R10: Hypervisor load/store executes in M and HS. In U it executes when `h_hu` = 1 and is illegal when `h_hu` = 0. In VS and VU it is virtual.
- R11: When several class bits are set, illegal wins over virtual, and virtual wins over execute.
- R12: A mode code of 5 to 7 makes every asserted class illegal.
- R13: `out_ret_ok` is 1 only when the sret bit is set and the merged outcome is execute. `out_ret_mode` then holds the return mode code; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present; enables the output register |
| in_priv | input | 3 | Current privilege mode code |
| in_class | input | 7 | One-hot instruction class |
| m_tw | input | 1 | Machine wait trap control |
| m_tvm | input | 1 | Machine translation trap control |
| h_vtw | input | 1 | Hypervisor guest wait trap control |
| h_vtsr | input | 1 | Hypervisor guest sret trap control |
| h_vtvm | input | 1 | Hypervisor guest translation trap control |
| h_hu | input | 1 | Hypervisor load/store allowed in U-mode |
| h_spv | input | 1 | Previous virtualization state for sret |
| m_spp | input | 1 | Supervisor previous privilege bit |
| vs_spp | input | 1 | Guest supervisor previous privilege bit |
| out_valid | output | 1 | Registered result valid |
| out_code | output | 2 | Outcome code |
| out_ret_ok | output | 1 | Allowed sret result |
| out_ret_mode | output | 3 | Return mode code for an allowed sret |

## Verification
The wfi matrix is swept over every mode and every combination of the two wait controls. This separates the machine control's priority from the guest control and separates illegal traps from virtual ones. sret is swept over all modes and all previous-state bits, which checks the return-mode mapping independently of the trap path. The translation-related classes are run with both translation controls toggled in HS and VS; this shows which control acts in which mode and that hfence.vvma ignores them. Finally, long runs of random modes, including out-of-range codes, and random multi-bit class vectors with idle cycles exercise the severity merge and the hold behaviour.

// File: rtl/vtrap_pkg.sv
package vtrap_pkg;

  localparam int unsigned PRIV_W    = 3;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned NUM_CLASS = 7;

  localparam int unsigned CLS_WFI    = 0;
  localparam int unsigned CLS_SRET   = 1;
  localparam int unsigned CLS_SFENCE = 2;
  localparam int unsigned CLS_SINVAL = 3;
  localparam int unsigned CLS_SATP   = 4;
  localparam int unsigned CLS_HLS    = 5;
  localparam int unsigned CLS_HFENCE = 6;

  typedef enum logic [PRIV_W-1:0] {
    PRV_M  = 3'd0,
    PRV_HS = 3'd1,
    PRV_U  = 3'd2,
    PRV_VS = 3'd3,
    PRV_VU = 3'd4
  } prv_e;

  typedef enum logic [CODE_W-1:0] {
    OUT_EXEC = 2'b00,
    OUT_ILL  = 2'b01,
    OUT_VIRT = 2'b10
  } out_e;

  // Rule flavours shared by the translation-style classes
  typedef enum int unsigned {
    RULE_XLATE  = 0,
    RULE_HLS    = 1,
    RULE_HFENCE = 2
  } rule_e;

endpackage

// File: rtl/vtrap_wfi_rule.sv
module vtrap_wfi_rule
  import vtrap_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  input  logic              tw,
  input  logic              vtw,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    code = OUT_ILL;
    unique case (priv)
      PRV_M:   code = OUT_EXEC;
      PRV_HS:  code = tw ? OUT_ILL : OUT_EXEC;
      PRV_U:   code = OUT_ILL;
      PRV_VS: begin
        if (tw)       code = OUT_ILL;
        else if (vtw) code = OUT_VIRT;
        else          code = OUT_EXEC;
      end
      PRV_VU:  code = tw ? OUT_ILL : OUT_VIRT;
      default: code = OUT_ILL;
    endcase
  end

endmodule

// File: rtl/vtrap_sret_rule.sv
module vtrap_sret_rule
  import vtrap_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  input  logic              vtsr,
  input  logic              spv,
  input  logic              spp,
  input  logic              vs_spp,
  output logic [CODE_W-1:0] code,
  output logic [PRIV_W-1:0] target
);

  logic [PRIV_W-1:0] host_target;
  logic [PRIV_W-1:0] guest_target;

  always_comb begin
    if (spv) host_target = spp ? PRV_VS : PRV_VU;
    else     host_target = spp ? PRV_HS : PRV_U;
    guest_target = vs_spp ? PRV_VS : PRV_VU;
  end

  always_comb begin
    code   = OUT_ILL;
    target = '0;
    unique case (priv)
      PRV_M, PRV_HS: begin
        code   = OUT_EXEC;
        target = host_target;
      end
      PRV_VS: begin
        if (vtsr) begin
          code = OUT_VIRT;
        end else begin
          code   = OUT_EXEC;
          target = guest_target;
        end
      end
      PRV_VU:  code = OUT_VIRT;
      default: code = OUT_ILL;
    endcase
  end

endmodule

// File: rtl/vtrap_mem_rule.sv
module vtrap_mem_rule
  import vtrap_pkg::*;
#(
  parameter int unsigned RULE = RULE_XLATE
) (
  input  logic [PRIV_W-1:0] priv,
  input  logic              tvm,
  input  logic              vtvm,
  input  logic              hu,
  output logic [CODE_W-1:0] code
);

  logic hs_ill;
  logic u_ill;
  logic vs_virt;

  generate
    if (RULE == RULE_XLATE) begin : g_xlate
      assign hs_ill  = tvm;
      assign u_ill   = 1'b1;
      assign vs_virt = vtvm;
    end else if (RULE == RULE_HLS) begin : g_hls
      assign hs_ill  = 1'b0;
      assign u_ill   = ~hu;
      assign vs_virt = 1'b1;
    end else begin : g_hfence
      assign hs_ill  = 1'b0;
      assign u_ill   = 1'b1;
      assign vs_virt = 1'b1;
    end
  endgenerate

  always_comb begin
    code = OUT_ILL;
    unique case (priv)
      PRV_M:   code = OUT_EXEC;
      PRV_HS:  code = hs_ill  ? OUT_ILL  : OUT_EXEC;
      PRV_U:   code = u_ill   ? OUT_ILL  : OUT_EXEC;
      PRV_VS:  code = vs_virt ? OUT_VIRT : OUT_EXEC;
      PRV_VU:  code = OUT_VIRT;
      default: code = OUT_ILL;
    endcase
  end

endmodule

// File: rtl/vtrap_checker.sv
module vtrap_checker
  import vtrap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [PRIV_W-1:0]    in_priv,
  input  logic [NUM_CLASS-1:0] in_class,
  input  logic                 m_tw,
  input  logic                 m_tvm,
  input  logic                 h_vtw,
  input  logic                 h_vtsr,
  input  logic                 h_vtvm,
  input  logic                 h_hu,
  input  logic                 h_spv,
  input  logic                 m_spp,
  input  logic                 vs_spp,
  output logic                 out_valid,
  output logic [CODE_W-1:0]    out_code,
  output logic                 out_ret_ok,
  output logic [PRIV_W-1:0]    out_ret_mode
);

  logic [CODE_W-1:0] cls_code [NUM_CLASS];
  logic [PRIV_W-1:0] sret_target;

  // Per-class rule instances
  vtrap_wfi_rule i_wfi (
    .priv (in_priv),
    .tw   (m_tw),
    .vtw  (h_vtw),
    .code (cls_code[CLS_WFI])
  );

  vtrap_sret_rule i_sret (
    .priv   (in_priv),
    .vtsr   (h_vtsr),
    .spv    (h_spv),
    .spp    (m_spp),
    .vs_spp (vs_spp),
    .code   (cls_code[CLS_SRET]),
    .target (sret_target)
  );

  genvar g;
  generate
    for (g = CLS_SFENCE; g < NUM_CLASS; g++) begin : g_mem
      localparam int unsigned RSEL = (g == CLS_HLS)    ? RULE_HLS :
                                     (g == CLS_HFENCE) ? RULE_HFENCE : RULE_XLATE;
      vtrap_mem_rule #(.RULE(RSEL)) i_rule (
        .priv (in_priv),
        .tvm  (m_tvm),
        .vtvm (h_vtvm),
        .hu   (h_hu),
        .code (cls_code[g])
      );
    end
  endgenerate

  // Severity merge: illegal over virtual over execute
  logic              any_ill;
  logic              any_virt;
  logic [CODE_W-1:0] code_nxt;
  logic              ret_ok_nxt;
  logic [PRIV_W-1:0] ret_mode_nxt;

  always_comb begin
    any_ill  = 1'b0;
    any_virt = 1'b0;
    for (int i = 0; i < NUM_CLASS; i++) begin
      if (in_class[i]) begin
        any_ill  = any_ill  | (cls_code[i] == OUT_ILL);
        any_virt = any_virt | (cls_code[i] == OUT_VIRT);
      end
    end
    if (any_ill)       code_nxt = OUT_ILL;
    else if (any_virt) code_nxt = OUT_VIRT;
    else               code_nxt = OUT_EXEC;
    ret_ok_nxt   = in_class[CLS_SRET] & (code_nxt == OUT_EXEC);
    ret_mode_nxt = ret_ok_nxt ? sret_target : '0;
  end

  // Output register stage
  logic              valid_q;
  logic [CODE_W-1:0] code_q;
  logic              ret_ok_q;
  logic [PRIV_W-1:0] ret_mode_q;
  logic              valid_d;
  logic [CODE_W-1:0] code_d;
  logic              ret_ok_d;
  logic [PRIV_W-1:0] ret_mode_d;

  always_comb begin
    valid_d    = in_valid;
    code_d     = code_q;
    ret_ok_d   = ret_ok_q;
    ret_mode_d = ret_mode_q;
    if (in_valid) begin
      code_d     = code_nxt;
      ret_ok_d   = ret_ok_nxt;
      ret_mode_d = ret_mode_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      code_q     <= OUT_EXEC;
      ret_ok_q   <= 1'b0;
      ret_mode_q <= '0;
    end else begin
      valid_q    <= valid_d;
      code_q     <= code_d;
      ret_ok_q   <= ret_ok_d;
      ret_mode_q <= ret_mode_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_code     = code_q;
  assign out_ret_ok   = ret_ok_q;
  assign out_ret_mode = ret_mode_q;

  // Checks next to the merge and register stage
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_code != 2'b11);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_code) && $stable(out_ret_ok) && !out_valid));

  p_mmode_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_priv == PRV_M) |=> out_code == OUT_EXEC);

  p_wfi_tw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == NUM_CLASS'(1 << CLS_WFI) && m_tw && in_priv != PRV_M)
      |=> out_code == OUT_ILL);

  p_vtsr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class[CLS_SRET] && in_priv == PRV_VS && h_vtsr)
      |=> (out_code != OUT_EXEC && !out_ret_ok));

  p_ret_ok_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_ret_ok |-> out_code == OUT_EXEC);

endmodule

// File: tb/test_vtrap_checker.sv
module test_vtrap_checker;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [2:0] in_priv;
  logic [6:0] in_class;
  logic       m_tw, m_tvm, h_vtw, h_vtsr, h_vtvm, h_hu, h_spv, m_spp, vs_spp;
  logic       out_valid;
  logic [1:0] out_code;
  logic       out_ret_ok;
  logic [2:0] out_ret_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Expected state of the outputs
  logic [1:0] e_code;
  logic       e_ok;
  logic [2:0] e_mode;

  vtrap_checker i_vtrap_checker (
    .clk, .rst_n, .in_valid, .in_priv, .in_class,
    .m_tw, .m_tvm, .h_vtw, .h_vtsr, .h_vtvm, .h_hu, .h_spv, .m_spp, .vs_spp,
    .out_valid, .out_code, .out_ret_ok, .out_ret_mode
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: returns {code, ok, mode}
  function automatic logic [5:0] ref_model();
    bit ill = 0, virt = 0;
    int p = in_priv;
    logic [2:0] tgt = 0;
    logic [1:0] c;
    logic ok;
    for (int k = 0; k < 7; k++) begin
      if (!in_class[k]) continue;
      c = 2'b00;
      if (p > 4) c = 2'b01;
      else if (p == 0) c = 2'b00;
      else if (k == 0) begin
        if (m_tw || p == 2) c = 2'b01;
        else if (p == 4 || (p == 3 && h_vtw)) c = 2'b10;
      end else if (k == 1) begin
        if (p == 2) c = 2'b01;
        else if (p == 4 || (p == 3 && h_vtsr)) c = 2'b10;
      end else if (k <= 4) begin
        if (p == 2 || (p == 1 && m_tvm)) c = 2'b01;
        else if (p == 4 || (p == 3 && h_vtvm)) c = 2'b10;
      end else if (k == 5) begin
        if (p == 2 && !h_hu) c = 2'b01;
        else if (p >= 3) c = 2'b10;
      end else begin
        if (p == 2) c = 2'b01;
        else if (p >= 3) c = 2'b10;
      end
      if (c == 2'b01) ill = 1;
      if (c == 2'b10) virt = 1;
    end
    c  = ill ? 2'b01 : (virt ? 2'b10 : 2'b00);
    ok = in_class[1] && c == 2'b00;
    if (ok) begin
      if (p == 3)      tgt = vs_spp ? 3'd3 : 3'd4;
      else if (h_spv)  tgt = m_spp ? 3'd3 : 3'd4;
      else             tgt = m_spp ? 3'd1 : 3'd2;
    end
    return {c, ok, tgt};
  endfunction

  task automatic check_now(string tag, bit exp_valid);
    checks++;
    if (out_valid !== exp_valid || out_code !== e_code ||
        out_ret_ok !== e_ok || out_ret_mode !== e_mode) begin
      errors++;
      $display("FAIL %s priv=%0d class=%b: got v=%b code=%b ok=%b mode=%0d exp v=%b code=%b ok=%b mode=%0d",
               tag, in_priv, in_class, out_valid, out_code, out_ret_ok, out_ret_mode,
               exp_valid, e_code, e_ok, e_mode);
    end
  endtask

  // One clock: model the register, then sample a quarter period after the edge
  task automatic cycle(string tag);
    bit v = in_valid;
    if (v) {e_code, e_ok, e_mode} = ref_model();
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_now(tag, v);
  endtask

  task automatic set_ctl(bit tw, bit tvm, bit vtw, bit vtsr, bit vtvm, bit hu,
                         bit spv, bit spp, bit vspp);
    m_tw = tw; m_tvm = tvm; h_vtw = vtw; h_vtsr = vtsr; h_vtvm = vtvm;
    h_hu = hu; h_spv = spv; m_spp = spp; vs_spp = vspp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_priv = 0; in_class = 0;
    set_ctl(0,0,0,0,0,0,0,0,0);
    e_code = 0; e_ok = 0; e_mode = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check_now("R1 reset", 1'b0);
    rst_n = 1'b1;
    in_valid = 1;

    // R3 R4: wfi matrix over modes and both wait controls
    for (int p = 0; p < 5; p++)
      for (int t = 0; t < 4; t++) begin
        in_priv = 3'(p); in_class = 7'b0000001;
        set_ctl(t[1], 0, t[0], 0, 0, 0, 0, 0, 0);
        cycle(t[1] ? "R3 wfi" : "R4 wfi");
      end

    // R5 R6 R13: sret over modes and previous-state bits
    for (int p = 0; p < 5; p++)
      for (int b = 0; b < 16; b++) begin
        in_priv = 3'(p); in_class = 7'b0000010;
        set_ctl(0, 0, 0, b[3], 0, 0, b[2], b[1], b[0]);
        cycle(p == 3 ? "R5 sret" : "R6 R13 sret");
      end

    // R7 R8 R9: translation classes and hfence under both controls
    for (int k = 2; k < 7; k++)
      if (k != 5)
        for (int p = 0; p < 5; p++)
          for (int t = 0; t < 4; t++) begin
            in_priv = 3'(p); in_class = 7'(1 << k);
            set_ctl(0, t[1], 0, 0, t[0], 0, 0, 0, 0);
            cycle(k == 6 ? "R9 hfence" : (t[1] ? "R8 tvm" : "R7 vtvm"));
          end

    // R10: hypervisor load/store
    for (int p = 0; p < 5; p++)
      for (int h = 0; h < 2; h++) begin
        in_priv = 3'(p); in_class = 7'b0100000;
        set_ctl(0, 0, 0, 0, 0, h[0], 0, 0, 0);
        cycle("R10 hls");
      end

    // R2: no class bit, every mode
    for (int p = 0; p < 8; p++) begin
      in_priv = 3'(p); in_class = 0;
      set_ctl(1, 1, 1, 1, 1, 0, 0, 0, 0);
      cycle("R2 none");
    end

    // R12: out-of-range mode codes
    for (int p = 5; p < 8; p++) begin
      in_priv = 3'(p); in_class = 7'b0100000;
      set_ctl(0, 0, 0, 0, 0, 1, 0, 0, 0);
      cycle("R12 badmode");
    end

    // R11: virtual plus illegal in one vector
    in_priv = 3'd4; in_class = 7'b0000011;
    set_ctl(1, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle("R11 merge");
    // Allowed sret suppressed by a trapping neighbour
    in_priv = 3'd1; in_class = 7'b0000110;
    set_ctl(0, 1, 0, 0, 0, 0, 1, 1, 0);
    cycle("R11 R13 merge");

    // R1: hold while idle with changed inputs
    in_priv = 3'd1; in_class = 7'b0000010;
    set_ctl(0, 0, 0, 0, 0, 0, 1, 0, 0);
    cycle("R1 load");
    in_valid = 0; in_priv = 3'd2; in_class = 7'b0000001;
    cycle("R1 hold");
    cycle("R1 hold");
    in_valid = 1;

    // R11 R1: random mixture
    for (int n = 0; n < 3000; n++) begin
      in_valid = ($urandom_range(0, 7) != 0);
      in_priv  = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7))
                                             : 3'($urandom_range(0, 4));
      in_class = ($urandom_range(0, 3) == 0) ? 7'($urandom)
                                             : 7'(1 << $urandom_range(0, 6));
      set_ctl($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
              $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
              $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1));
      cycle("R11 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule